// File: doc/BRIEF.md
# Dual-Clock Read Buffer with Width Down-Converter

The block sits between a read request generator in the user clock domain and an AXI4 read master in the AXI clock domain. Burst commands, each an address and an 8-bit beat count, are accepted in the user clock and queued in a small dual-clock FIFO. A controller in the AXI clock domain hands them to the master one at a time through a level request and ready handshake. It does not issue the next command until the current burst's final beat has returned.

Wide read beats returned by the master are stored with their end-of-burst flag in a second dual-clock FIFO. The user clock domain reads each wide word once and shifts it out as 16-bit slices, least-significant slice first, one per cycle. The end-of-burst marker appears only on the final slice of a burst's final word. Each clock domain has its own reset synchroniser fed by a single asynchronous active-low reset.

Top module: `rd_buf_dnconv`

## Requirements
- R1: `cmd_rdy_o` is high exactly while the command FIFO's write-side fill is below 6 of its 8 entries. A command is stored only on a user cycle where `cmd_req_i` and `cmd_rdy_o` are both high.
- R2: Commands reach the master in the order they were accepted. While `mst_req_o` is high, `mst_addr_o` and `mst_len_o` show the oldest unissued command. That command is removed on the cycle where `mst_req_o` and `mst_rdy_i` are both high.
- R3: `mst_req_o` rises only after a cycle in which the command FIFO was non-empty and the data FIFO was not full. It then holds with a stable address until `mst_rdy_i` is seen, and is low on the cycle after the handshake.
- R4: After a handshake, `mst_req_o` stays low until a beat with `beat_last_i` high has been received.
- R5: Every beat with `beat_vld_i` high is stored with its last flag, which is kept at bit 128 of the 129-bit data FIFO entry. The environment never presents a beat while the data FIFO is full.
- R6: Each stored wide word is output as 8 consecutive `usr_vld_o` cycles carrying bits [15:0], [31:16], … [127:112] in that order. Words appear in the order their beats arrived.
- R7: `usr_last_o` is high only together with `usr_vld_o`, on the eighth slice of a word stored with its last flag set, which gives exactly one marker per burst.
- R8: Each data FIFO read is a one-cycle pulse that is issued only while no slice of an earlier word is pending. As a result, `usr_vld_o` is never high for more than 8 consecutive cycles.
- R9: While reset is asserted and after it is released, `usr_vld_o`, `usr_last_o` and `mst_req_o` are low, both FIFOs are empty, and `cmd_rdy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_usr_i | input | 1 | User-side clock |
| clk_axi_i | input | 1 | AXI-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_req_i | input | 1 | Command offered (user clock) |
| cmd_addr_i | input | 32 | Burst start address |
| cmd_len_i | input | 8 | Burst length in beats minus one |
| cmd_rdy_o | output | 1 | Command FIFO has room |
| mst_req_o | output | 1 | Request to the read master (AXI clock) |
| mst_rdy_i | input | 1 | Master accepts the request |
| mst_addr_o | output | 32 | Address of the offered command |
| mst_len_o | output | 8 | Length of the offered command |
| beat_vld_i | input | 1 | Returned wide beat valid (AXI clock) |
| beat_data_i | input | 128 | Returned wide beat |
| beat_last_i | input | 1 | Beat is the last of its burst |
| usr_vld_o | output | 1 | Narrow slice valid (user clock) |
| usr_data_o | output | 16 | Narrow slice |
| usr_last_o | output | 1 | Final slice of a burst |

## Verification
The assertions check the per-cycle rules on every cycle. These are the request level held with a stable address until accepted, the gap after each handshake, the absence of a new request during a burst, single-cycle FIFO reads, no read from an empty FIFO and no write into a full one, and a gap after each end marker. Only the bench scenarios can show the end-to-end properties. These include the ready threshold reached by filling the command queue while the master stalls, the order of commands as seen at the master, the slice order against the beat order across the clock crossing, and one end marker per burst over a run of mixed burst lengths with a stalling handshake.

// File: rtl/rdb_pkg.sv
package rdb_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] addr;
  } rdb_cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DATA} rdb_state_e;
endpackage

// File: rtl/rdb_rst_sync.sv
module rdb_rst_sync #(
  parameter int STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/rdb_afifo.sv
module rdb_afifo #(
  parameter int W     = 40,
  parameter int DEPTH = 8
) (
  input  logic           wclk_i,
  input  logic           wrst_ni,
  input  logic           we_i,
  input  logic [W-1:0]   wdata_i,
  output logic [$clog2(DEPTH):0] wfill_o,
  input  logic           rclk_i,
  input  logic           rrst_ni,
  input  logic           re_i,
  output logic [W-1:0]   rdata_o,
  output logic           empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] rg_s1_q, rg_s2_q, wg_s1_q, wg_s2_q;
  logic          full, wr_ok, rd_ok;

  assign wfill_o = wbin_q - from_gray(rg_s2_q);
  assign full    = (wfill_o == PW'(DEPTH));
  assign wr_ok   = we_i && !full;
  assign empty_o = (rgray_q == wg_s2_q);
  assign rd_ok   = re_i && !empty_o;
  assign rdata_o = mem[rbin_q[AW-1:0]];

  always_ff @(posedge wclk_i) begin
    if (wr_ok) mem[wbin_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      rg_s1_q <= '0;
      rg_s2_q <= '0;
    end else begin
      rg_s1_q <= rgray_q;
      rg_s2_q <= rg_s1_q;
      if (wr_ok) begin
        wbin_q  <= wbin_q + 1'b1;
        wgray_q <= to_gray(wbin_q + 1'b1);
      end
    end
  end

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      wg_s1_q <= '0;
      wg_s2_q <= '0;
    end else begin
      wg_s1_q <= wgray_q;
      wg_s2_q <= wg_s1_q;
      if (rd_ok) begin
        rbin_q  <= rbin_q + 1'b1;
        rgray_q <= to_gray(rbin_q + 1'b1);
      end
    end
  end

  // R5: writer never pushes into a full FIFO
  p_no_overflow_r5: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    we_i |-> !full);
  // R2: reader never pops an empty FIFO
  p_no_underflow_r2: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    re_i |-> !empty_o);
endmodule

// File: rtl/rdb_ctrl.sv
module rdb_ctrl
  import rdb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_empty_i,
  input  logic dat_full_i,
  input  logic mst_rdy_i,
  input  logic beat_vld_i,
  input  logic beat_last_i,
  output logic mst_req_o,
  output logic cmd_pop_o
);
  rdb_state_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else begin
      case (st_q)
        ST_IDLE: if (!cmd_empty_i && !dat_full_i) st_q <= ST_REQ;
        ST_REQ:  if (mst_rdy_i) st_q <= ST_DATA;
        ST_DATA: if (beat_vld_i && beat_last_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mst_req_o = (st_q == ST_REQ);
  assign cmd_pop_o = mst_req_o && mst_rdy_i;

  // R3: request starts only with a command queued and room for data
  p_req_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mst_req_o) |-> $past(!cmd_empty_i && !dat_full_i));
  // R3: request level held until accepted
  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_req_o && !mst_rdy_i |=> mst_req_o);
  // R3: request drops after handshake
  p_req_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_req_o && mst_rdy_i |=> !mst_req_o);
  // R4: no request while the burst is still returning
  p_one_burst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mst_req_o && !$rose(mst_req_o) && (st_q == ST_DATA) && !(beat_vld_i && beat_last_i) |=> !mst_req_o);
endmodule

// File: rtl/rdb_dnconv.sv
module rdb_dnconv #(
  parameter int WW = 128,
  parameter int UW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          empty_i,
  input  logic [WW:0]   rdata_i,
  output logic          re_o,
  output logic          usr_vld_o,
  output logic [UW-1:0] usr_data_o,
  output logic          usr_last_o
);
  localparam int NS = WW / UW;
  localparam int CW = (NS > 1) ? $clog2(NS) : 1;

  logic [WW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, last_q, fin;

  assign fin  = (cnt_q == CW'(NS - 1));
  assign re_o = !busy_q && !empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      last_q <= 1'b0;
    end else if (re_o) begin
      sh_q   <= rdata_i[WW-1:0];
      last_q <= rdata_i[WW];
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      sh_q  <= sh_q >> UW;
      cnt_q <= cnt_q + 1'b1;
      if (fin) busy_q <= 1'b0;
    end
  end

  assign usr_vld_o  = busy_q;
  assign usr_data_o = sh_q[UW-1:0];
  assign usr_last_o = busy_q && last_q && fin;

  // R8: read is a single-cycle pulse
  p_rd_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_o |=> !re_o);
  // R7: end marker closes the word
  p_last_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usr_last_o |=> !usr_vld_o);
endmodule

// File: rtl/rd_buf_dnconv.sv
module rd_buf_dnconv
  import rdb_pkg::*;
#(
  parameter int WW         = 128,
  parameter int UW         = 16,
  parameter int CMD_DEPTH  = 8,
  parameter int CMD_MARGIN = 2,
  parameter int DAT_DEPTH  = 16
) (
  input  logic              clk_usr_i,
  input  logic              clk_axi_i,
  input  logic              rst_ni,
  input  logic              cmd_req_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  output logic              cmd_rdy_o,
  output logic              mst_req_o,
  input  logic              mst_rdy_i,
  output logic [ADDR_W-1:0] mst_addr_o,
  output logic [LEN_W-1:0]  mst_len_o,
  input  logic              beat_vld_i,
  input  logic [WW-1:0]     beat_data_i,
  input  logic              beat_last_i,
  output logic              usr_vld_o,
  output logic [UW-1:0]     usr_data_o,
  output logic              usr_last_o
);
  localparam int CMD_W  = $bits(rdb_cmd_t);
  localparam int CMD_PW = $clog2(CMD_DEPTH) + 1;
  localparam int DAT_PW = $clog2(DAT_DEPTH) + 1;

  logic rst_usr_n, rst_axi_n;
  logic [CMD_PW-1:0] cmd_fill;
  logic [DAT_PW-1:0] dat_fill;
  logic [CMD_W-1:0]  cmd_rdata;
  logic [WW:0]       dat_rdata;
  logic cmd_empty, cmd_pop, dat_full, dat_empty, dat_re;
  rdb_cmd_t cmd_in, cmd_head;

  rdb_rst_sync #(.STAGES(3)) u_rs_usr (.clk_i(clk_usr_i), .rst_ni(rst_ni), .rst_no(rst_usr_n));
  rdb_rst_sync #(.STAGES(3)) u_rs_axi (.clk_i(clk_axi_i), .rst_ni(rst_ni), .rst_no(rst_axi_n));

  assign cmd_rdy_o   = cmd_fill < CMD_PW'(CMD_DEPTH - CMD_MARGIN);
  assign cmd_in.len  = cmd_len_i;
  assign cmd_in.addr = cmd_addr_i;

  rdb_afifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .wclk_i(clk_usr_i), .wrst_ni(rst_usr_n), .we_i(cmd_req_i && cmd_rdy_o),
    .wdata_i(cmd_in), .wfill_o(cmd_fill),
    .rclk_i(clk_axi_i), .rrst_ni(rst_axi_n), .re_i(cmd_pop),
    .rdata_o(cmd_rdata), .empty_o(cmd_empty)
  );

  assign cmd_head   = rdb_cmd_t'(cmd_rdata);
  assign mst_addr_o = cmd_head.addr;
  assign mst_len_o  = cmd_head.len;

  rdb_ctrl u_ctrl (
    .clk_i(clk_axi_i), .rst_ni(rst_axi_n), .cmd_empty_i(cmd_empty),
    .dat_full_i(dat_full), .mst_rdy_i(mst_rdy_i), .beat_vld_i(beat_vld_i),
    .beat_last_i(beat_last_i), .mst_req_o(mst_req_o), .cmd_pop_o(cmd_pop)
  );

  assign dat_full = (dat_fill == DAT_PW'(DAT_DEPTH));

  rdb_afifo #(.W(WW + 1), .DEPTH(DAT_DEPTH)) u_dat_fifo (
    .wclk_i(clk_axi_i), .wrst_ni(rst_axi_n), .we_i(beat_vld_i),
    .wdata_i({beat_last_i, beat_data_i}), .wfill_o(dat_fill),
    .rclk_i(clk_usr_i), .rrst_ni(rst_usr_n), .re_i(dat_re),
    .rdata_o(dat_rdata), .empty_o(dat_empty)
  );

  rdb_dnconv #(.WW(WW), .UW(UW)) u_dnconv (
    .clk_i(clk_usr_i), .rst_ni(rst_usr_n), .empty_i(dat_empty),
    .rdata_i(dat_rdata), .re_o(dat_re), .usr_vld_o(usr_vld_o),
    .usr_data_o(usr_data_o), .usr_last_o(usr_last_o)
  );

  // R2: offered command stable while request waits
  p_addr_stable_r2: assert property (@(posedge clk_axi_i) disable iff (!rst_axi_n)
    mst_req_o && !mst_rdy_i |=> $stable(mst_addr_o) && $stable(mst_len_o));
  // R1: stored commands never exceed the threshold
  p_cmd_fill_r1: assert property (@(posedge clk_usr_i) disable iff (!rst_usr_n)
    cmd_fill <= CMD_PW'(CMD_DEPTH - CMD_MARGIN));
endmodule

// File: tb/rd_buf_dnconv_tb_top.sv
module rd_buf_dnconv_tb_top;
  logic clk_usr_i = 0, clk_axi_i = 0, rst_ni = 0;
  logic cmd_req_i = 0, mst_rdy_i = 0, beat_vld_i = 0, beat_last_i = 0;
  logic [31:0] cmd_addr_i = 0;
  logic [7:0] cmd_len_i = 0;
  logic [127:0] beat_data_i = 0;
  logic cmd_rdy_o, mst_req_o, usr_vld_o, usr_last_o;
  logic [31:0] mst_addr_o;
  logic [7:0] mst_len_o;
  logic [15:0] usr_data_o;

  always #4 clk_usr_i = ~clk_usr_i;
  always #5 clk_axi_i = ~clk_axi_i;

  rd_buf_dnconv dut_i (.*);

  localparam int NCMD = 10;
  int n_chk = 0, n_fail = 0, nid = 0, hs = 0, lasts = 0, words = 0, exp_words = 0;
  int runlen = 0, bcnt = 0;
  bit allow_rdy = 0, mon_on = 0, done = 0;
  logic [39:0] cmdq[$];
  logic [16:0] refq[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic offer_cmd();
    cmd_req_i  = 1;
    cmd_addr_i = 32'h0001_0000 + 32'(nid) * 32'h400;
    cmd_len_i  = 8'(nid % 4);
    if (cmd_rdy_o) begin
      cmdq.push_back({cmd_len_i, cmd_addr_i});
      nid++;
    end
  endtask

  // user-side reference comparison every clock
  always @(negedge clk_usr_i) if (mon_on) begin
    runlen = usr_vld_o ? runlen + 1 : 0;
    chk(runlen <= 8, "R8", 64'(runlen), 64'd8);
    if (usr_vld_o) begin
      if (refq.size() == 0) chk(0, "R6", {47'd0, usr_last_o, usr_data_o}, 64'd0);
      else begin
        logic [16:0] e;
        e = refq.pop_front();
        words++;
        chk(usr_data_o == e[15:0], "R6", 64'(usr_data_o), 64'(e[15:0]));
        chk(usr_last_o == e[16], "R7", 64'(usr_last_o), 64'(e[16]));
        if (usr_last_o) lasts++;
      end
    end else chk(usr_last_o == 0, "R7", 64'(usr_last_o), 64'd0);
  end

  // AXI-side master model with back-pressure
  initial begin
    int acyc = 0;
    forever begin
      @(negedge clk_axi_i);
      mst_rdy_i = allow_rdy && (acyc % 3 == 2);
      acyc++;
      if (mst_req_o && mst_rdy_i) begin
        logic [39:0] e;
        e = cmdq.pop_front();
        chk({mst_len_o, mst_addr_o} == e, "R2", 64'({mst_len_o, mst_addr_o}), 64'(e));
        hs++;
        @(negedge clk_axi_i);
        mst_rdy_i = 0;
        chk(!mst_req_o, "R3", 64'(mst_req_o), 64'd0);
        while (refq.size() != 0) begin
          @(negedge clk_axi_i);
          chk(!mst_req_o, "R4", 64'(mst_req_o), 64'd0);
        end
        for (int b = 0; b <= int'(e[39:32]); b++) begin
          for (int s = 0; s < 8; s++) begin
            beat_data_i[s*16 +: 16] = {12'(bcnt), 4'(s)};
            refq.push_back({(b == int'(e[39:32])) && (s == 7), 12'(bcnt), 4'(s)});
          end
          exp_words += 8;
          bcnt++;
          beat_vld_i  = 1;
          beat_last_i = (b == int'(e[39:32]));
          chk(!mst_req_o, "R4", 64'(mst_req_o), 64'd0);
          @(negedge clk_axi_i);
          beat_vld_i  = 0;
          beat_last_i = 0;
          if (b % 2 == 1) @(negedge clk_axi_i);
        end
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk_usr_i);
    chk(!usr_vld_o && !usr_last_o, "R9", 64'(usr_vld_o), 64'd0);
    chk(!mst_req_o, "R9", 64'(mst_req_o), 64'd0);
    rst_ni = 1;
    repeat (10) @(negedge clk_usr_i);
    chk(cmd_rdy_o, "R9", 64'(cmd_rdy_o), 64'd1);
    chk(!usr_vld_o && !mst_req_o, "R9", 64'(usr_vld_o), 64'd0);
    mon_on = 1;
    // R1: master stalled, fill the command queue
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_usr_i);
      offer_cmd();
    end
    @(negedge clk_usr_i);
    cmd_req_i = 0;
    chk(nid == 6, "R1", 64'(nid), 64'd6);
    chk(!cmd_rdy_o, "R1", 64'(cmd_rdy_o), 64'd0);
    repeat (10) @(negedge clk_usr_i);
    chk(mst_req_o, "R3", 64'(mst_req_o), 64'd1);
    chk(mst_addr_o == 32'h0001_0000, "R2", 64'(mst_addr_o), 64'h10000);
    chk(!usr_vld_o, "R5", 64'(usr_vld_o), 64'd0);
    allow_rdy = 1;
    while (nid < NCMD) begin
      @(negedge clk_usr_i);
      offer_cmd();
      @(negedge clk_usr_i);
      cmd_req_i = 0;
    end
    while (hs < NCMD || refq.size() != 0) @(negedge clk_usr_i);
    repeat (40) @(negedge clk_usr_i);
    chk(lasts == NCMD, "R7", 64'(lasts), 64'(NCMD));
    chk(words == exp_words, "R6", 64'(words), 64'(exp_words));
    chk(!usr_vld_o, "R8", 64'(usr_vld_o), 64'd0);
    chk(cmd_rdy_o && !mst_req_o, "R1", 64'(cmd_rdy_o), 64'd1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_usr_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d handshakes", hs, NCMD);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule